// File: doc/BRIEF.md
# Prescaled Timer with Alarm and Interrupt Pending/Enable Controller

The block holds a free-running up-counter that advances once every `PRESCALE` core clocks (128 by default). It also holds an alarm compare register. When the counter ticks onto the alarm value, interrupt source 0 becomes pending. The remaining interrupt sources are peripheral lines on an input bus. A low-to-high edge on one of these lines latches its pending bit.

Software sees four word registers through a simple single-cycle register port. The four registers are the counter, the alarm, the pending set and the enable mask. Pending bits are cleared by writing ones. The single interrupt output is high while any pending bit is also enabled.

The register port has no handshake. A write is taken on every clock edge where `reg_wr_en` is high, so it cannot be back-pressured. Read data is a combinational function of `reg_addr` and the current register state.

Top module: `tmr_alarm_irq`

## Requirements
- R1: After reset the counter, alarm, pending and enable registers all read zero and `irq_o` is low.
- R2: Without register writes, the counter holds its value for `PRESCALE`-1 clocks and then increases by one on the next clock. After reset is released, the first increase lands on the `PRESCALE`-th rising edge.
- R3: The counter is `TIMER_W` bits wide. Stepping past its all-ones value gives zero.
- R4: Writing address 0 loads the counter. Writing address 0 or address 1 restarts the prescaler, so the next increase comes `PRESCALE` edges after the write edge.
- R5: The register map is: address 0 counter, 1 alarm, 2 pending, 3 enable. Writes keep only the low bits that fit the register. Reads return the register value zero-extended to 32 bits.
- R6: Pending bit 0 is set on the edge where a prescaler tick moves the counter onto the alarm value. Loading the counter directly with the alarm value does not set it.
- R7: For each i from 1 to `NUM_IRQ`-1, a rising edge on `irq_src_i[i]` sets pending bit i. A line that simply stays high does not set the bit again after it has been cleared.
- R8: Writing address 2 clears every pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R9: If a set and a write-one clear hit the same pending bit on the same edge, the bit ends up set.
- R10: `irq_o` is high exactly when the bitwise AND of the pending and enable registers is non-zero. It follows register changes within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per asserted edge |
| reg_addr | input | 2 | Register select for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, zero-extended |
| irq_src_i | input | NUM_IRQ-1 | Peripheral interrupt lines, indexed 1 to NUM_IRQ-1 |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The bench builds the block with `TIMER_W`=8, `PRESCALE`=8 and `NUM_IRQ`=4. The narrow counter makes the all-ones wrap reachable within a few dozen cycles. It also lets a 16-bit write demonstrate truncation on read-back. The short prescale keeps every tick-spacing and alarm-timing check to single-digit cycle counts. Four interrupt bits are enough to show a masked source next to an enabled one. They also allow a set-versus-clear collision on a peripheral bit while the alarm bit is idle.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_ALARM = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_MASK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
  localparam bit POW2 = ((1 << CNT_W) == PRESCALE);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  generate
    if (POW2) begin : g_pow2
      // Counter wraps by itself; terminal state is all ones.
      assign at_last = &cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_cmp
      assign at_last = (cnt_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (at_last)   cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  // A restart swallows the tick that would otherwise land on the same edge.
  assign tick_o = at_last & ~restart_i;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               ld_count_i,
  input  logic               ld_alarm_i,
  input  logic [TIMER_W-1:0] wdata_i,
  output logic [TIMER_W-1:0] count_o,
  output logic [TIMER_W-1:0] alarm_o,
  output logic               hit_o
);
  logic [TIMER_W-1:0] count_q, alarm_q, count_inc;

  assign count_inc = count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_q <= '0;
    else if (ld_count_i) count_q <= wdata_i;
    else if (tick_i)     count_q <= count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alarm_q <= '0;
    else if (ld_alarm_i) alarm_q <= wdata_i;
  end

  // Event fires only when a tick steps the counter onto the alarm value.
  assign hit_o   = tick_i & (count_inc == alarm_q);
  assign count_o = count_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alarm_hit_i,
  input  logic [NUM_IRQ-1:1] src_i,
  input  logic               clr_wr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:1] src_d;
  logic [NUM_IRQ-1:0] set_vec, clr_vec, pending_q, enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_d <= '0;
    else        src_d <= src_i;
  end

  assign set_vec[0] = alarm_hit_i;
  assign clr_vec    = clr_wr_i ? wdata_i : '0;

  generate
    for (genvar i = 1; i < NUM_IRQ; i++) begin : g_edge
      assign set_vec[i] = src_i[i] & ~src_d[i];
    end
    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_pend
      // Set takes priority over a simultaneous write-one clear.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pending_q[b] <= 1'b0;
        else if (set_vec[b]) pending_q[b] <= 1'b1;
        else if (clr_vec[b]) pending_q[b] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable_q <= '0;
    else if (mask_wr_i) enable_q <= wdata_i;
  end

  assign pending_o = pending_q;
  assign enable_o  = enable_q;
  assign irq_o     = |(pending_q & enable_q);
endmodule

// File: rtl/tmr_alarm_irq.sv
module tmr_alarm_irq
  import tmr_irq_pkg::*;
#(
  parameter int TIMER_W  = 32,
  parameter int PRESCALE = 128,
  parameter int NUM_IRQ  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_IRQ-1:1] irq_src_i,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic               wr_count, wr_alarm, wr_pend, wr_mask, tick, hit;
  logic [TIMER_W-1:0] timer_q, alarm_q;
  logic [NUM_IRQ-1:0] pending_q, enable_q;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_count = reg_wr_en && (sel == SEL_COUNT);
  assign wr_alarm = reg_wr_en && (sel == SEL_ALARM);
  assign wr_pend  = reg_wr_en && (sel == SEL_PEND);
  assign wr_mask  = reg_wr_en && (sel == SEL_MASK);

  tmr_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_count | wr_alarm),
    .tick_o    (tick)
  );

  tmr_count #(.TIMER_W(TIMER_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .ld_count_i (wr_count),
    .ld_alarm_i (wr_alarm),
    .wdata_i    (reg_wdata[TIMER_W-1:0]),
    .count_o    (timer_q),
    .alarm_o    (alarm_q),
    .hit_o      (hit)
  );

  tmr_irq_ctrl #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .alarm_hit_i (hit),
    .src_i       (irq_src_i),
    .clr_wr_i    (wr_pend),
    .mask_wr_i   (wr_mask),
    .wdata_i     (reg_wdata[NUM_IRQ-1:0]),
    .pending_o   (pending_q),
    .enable_o    (enable_q),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_COUNT: reg_rdata = BUS_W'(timer_q);
      SEL_ALARM: reg_rdata = BUS_W'(alarm_q);
      SEL_PEND:  reg_rdata = BUS_W'(pending_q);
      default:   reg_rdata = BUS_W'(enable_q);
    endcase
  end
endmodule

// File: rtl/tmr_alarm_irq_chk.sv
module tmr_alarm_irq_chk #(
  parameter int TW       = 32,
  parameter int PRESCALE = 128,
  parameter int N        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [N-1:0]  wdata_lo,
  input logic [N-1:1]  src,
  input logic [TW-1:0] timer_q,
  input logic [TW-1:0] alarm_q,
  input logic [N-1:0]  pending_q,
  input logic [N-1:0]  enable_q,
  input logic          irq
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
  localparam logic [TW-1:0] ONE  = TW'(1);

  logic          wr_ta, wr_pd;
  logic [CW-1:0] gap;
  logic [N-1:1]  src_prev, rise;

  assign wr_ta = wr_en && (addr == 2'd0 || addr == 2'd1);
  assign wr_pd = wr_en && (addr == 2'd2);
  assign rise  = src & ~src_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap <= '0;
    else if (wr_ta)         gap <= '0;
    else if (gap == LAST)   gap <= '0;
    else                    gap <= gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src;
  end

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != LAST) && !wr_ta |=> $stable(timer_q)); // R2
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == LAST) && !wr_ta |=> timer_q == $past(timer_q) + ONE); // R3
  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q == alarm_q) && (timer_q != $past(timer_q)) && !$past(wr_ta)
      |-> pending_q[0]); // R6
  AST_SRC_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pending_q[N-1:1] & $past(rise)) == $past(rise))); // R7
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pd |=> ((pending_q[N-1:1] & $past(wdata_lo[N-1:1] & ~rise)) == '0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) || (pending_q == '0) |-> !irq); // R10
endmodule

bind tmr_alarm_irq tmr_alarm_irq_chk #(
  .TW(TIMER_W), .PRESCALE(PRESCALE), .N(NUM_IRQ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (reg_wr_en),
  .addr      (reg_addr),
  .wdata_lo  (reg_wdata[NUM_IRQ-1:0]),
  .src       (irq_src_i),
  .timer_q   (timer_q),
  .alarm_q   (alarm_q),
  .pending_q (pending_q),
  .enable_q  (enable_q),
  .irq       (irq_o)
);

// File: tb/tmr_alarm_irq_tb.sv
`timescale 1ns/100ps
module tmr_alarm_irq_tb;
  localparam int TW = 8;
  localparam int PS = 8;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NI-1:1] irq_src_i = '0;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  tmr_alarm_irq #(.TIMER_W(TW), .PRESCALE(PS), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src_i(irq_src_i),
    .irq_o(irq_o)
  );

  // {is_write, addr, value}; for reads, value is the expected read data (R5)
  localparam logic [34:0] VEC [0:8] = '{
    {1'b1, 2'd1, 32'h0000_00A5},
    {1'b0, 2'd1, 32'h0000_00A5},
    {1'b1, 2'd1, 32'h0000_1234},
    {1'b0, 2'd1, 32'h0000_0034},
    {1'b1, 2'd3, 32'hFFFF_FFFF},
    {1'b0, 2'd3, 32'h0000_000F},
    {1'b1, 2'd3, 32'h0000_0000},
    {1'b0, 2'd3, 32'h0000_0000},
    {1'b0, 2'd2, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.2;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
    end
    #1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1;  // released 1ns after an edge
    // R1 reset state
    rd(2'd0, rv); chk("R1 count", rv, 0);
    rd(2'd1, rv); chk("R1 alarm", rv, 0);
    rd(2'd2, rv); chk("R1 pending", rv, 0);
    rd(2'd3, rv); chk("R1 enable", rv, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    // R2 first increment on PS-th edge after release
    step(PS - 1); rd(2'd0, rv); chk("R2 hold", rv, 0);
    step(1);      rd(2'd0, rv); chk("R2 step", rv, 1);

    // Table walk: register map and truncation (R5)
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][34]) wr(VEC[i][33:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][33:32], rv);
        chk("R5 table", rv, VEC[i][31:0]);
      end
    end

    // R4 load and prescaler restart
    wr(2'd0, 32'h10);
    step(PS - 1); rd(2'd0, rv); chk("R4 load hold", rv, 32'h10);
    step(1);      rd(2'd0, rv); chk("R4 next step", rv, 32'h11);

    // R3 wrap
    wr(2'd0, 32'hFF);
    step(PS); rd(2'd0, rv); chk("R3 wrap", rv, 0);

    // R6 alarm
    wr(2'd2, 32'hF);
    wr(2'd1, 32'h5);
    wr(2'd0, 32'h4);
    step(PS - 1); rd(2'd2, rv); chk("R6 not yet", rv, 0);
    step(1);      rd(2'd0, rv); chk("R6 count", rv, 5);
    rd(2'd2, rv); chk("R6 pending0", rv, 1);
    chk("R10 masked", {31'd0, irq_o}, 0);
    wr(2'd3, 32'h1);
    chk("R10 enabled", {31'd0, irq_o}, 1);
    wr(2'd2, 32'h1);
    rd(2'd2, rv); chk("R8 clear bit0", rv, 0);
    chk("R10 drop", {31'd0, irq_o}, 0);
    wr(2'd0, 32'h5);
    rd(2'd2, rv); chk("R6 direct load no set", rv, 0);

    // R7 edges
    wr(2'd1, 32'h80);
    irq_src_i[1] = 1'b1;
    step(1); rd(2'd2, rv); chk("R7 rise sets", rv, 32'h2);
    wr(2'd2, 32'h2);
    step(1); rd(2'd2, rv); chk("R7 level no reset", rv, 0);
    // R9 set beats clear
    irq_src_i[2] = 1'b1;
    wr(2'd2, 32'h4);
    rd(2'd2, rv); chk("R9 set wins", rv, 32'h4);
    wr(2'd2, 32'h0);
    rd(2'd2, rv); chk("R8 zeros keep", rv, 32'h4);
    wr(2'd3, 32'h4);
    chk("R10 src irq", {31'd0, irq_o}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule